// File: doc/BRIEF.md
# Row-Hit-First Memory Request Scheduler

This block holds a short, age-ordered queue of pending memory requests. Each request names a bank, a row and a requesting thread. When the downstream command logic offers a slot, the scheduler hands over exactly one queued request. In its default policy it prefers requests that target the row already open in their bank, because those avoid a precharge and activate. Among candidates of equal readiness, the oldest one wins. A runtime mode switch turns off the preference and serves requests strictly in the order they arrived, so the two policies can be compared on the same traffic.

The scheduler keeps its own table of which row each bank holds open. Issuing a request that is not a hit makes its row the open row of that bank from the next cycle on. The command logic can report a bank precharge through a per-bank close input. Two counters report how many hits and how many misses have been issued. The queue raises a full flag, and it drops any enqueue that arrives while that flag is set.

Top module: `frfcfs_sched`

## Requirements
- R1: After reset the queue is empty (`full_o`=0, `issue_valid_o`=0), both counters are 0, and every bank is closed, so the first issued request has `issue_hit_o`=0.
- R2: A queued request is ready when the bank table marks its bank open and the recorded row equals its row. `issue_hit_o` is 1 exactly when the issued request is ready.
- R3: With `fcfs_mode_i`=0, any ready request is issued before every non-ready request, whatever their ages. A run of queued hits to an open row is fully served before an older miss to the same bank.
- R4: Among requests of equal readiness, the one enqueued earliest is issued first.
- R5: With `fcfs_mode_i`=1, requests are issued strictly in arrival order, regardless of readiness.
- R6: Issuing a non-ready request records its bank as open with its row from the next cycle on. Issuing a ready request leaves the table unchanged.
- R7: `bank_close_i[b]`=1 marks bank b closed from the next cycle on. If a miss to bank b issues in the same cycle, the new row is recorded open and the close has no effect.
- R8: `full_o` is 1 exactly when DEPTH requests are queued. An enqueue while `full_o`=1 is dropped and is never issued.
- R9: `issue_valid_o` = `issue_slot_i` AND (queue not empty), in the same cycle. An issued request leaves the queue at that clock edge. An accepted enqueue becomes eligible in the next cycle.
- R10: `hit_cnt_o` and `miss_cnt_o` each increase by one in the cycle after a hit or a miss is issued (wrapping at CNT_W bits). They hold otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fcfs_mode_i | input | 1 | 1: strict arrival order; 0: row hits first |
| enq_valid_i | input | 1 | Enqueue a request this cycle |
| enq_bank_i | input | BANK_W | Bank of the new request |
| enq_row_i | input | ROW_W | Row of the new request |
| enq_tid_i | input | TID_W | Thread ID of the new request |
| full_o | output | 1 | Queue holds DEPTH requests |
| bank_close_i | input | NUM_BANKS | Per-bank precharge notification |
| issue_slot_i | input | 1 | Command logic can take one request |
| issue_valid_o | output | 1 | A request is issued this cycle |
| issue_bank_o | output | BANK_W | Bank of the issued request |
| issue_row_o | output | ROW_W | Row of the issued request |
| issue_tid_o | output | TID_W | Thread ID of the issued request |
| issue_hit_o | output | 1 | Issued request hits the open row |
| hit_cnt_o | output | CNT_W | Issued hit count |
| miss_cnt_o | output | CNT_W | Issued miss count |

## Verification
A corrupted open-row table shows up at the next issue to the affected bank. `issue_hit_o` takes the wrong value in that cycle, and under the default policy a different request is selected. A wrong queue order or a lost compaction shows up at the following issue as an unexpected bank, row or thread. A stray or dropped enqueue shows up at `full_o` or as a missing or extra issue when the queue drains. The counters drift one cycle after the first wrongly classified issue. Because the reference model predicts every output in every cycle, any of these faults is reported in the cycle it first reaches a port.

// File: rtl/frfcfs_pkg.sv
package frfcfs_pkg;
  typedef enum logic {
    POL_READY_FIRST = 1'b0,
    POL_ARRIVAL     = 1'b1
  } policy_e;
endpackage

// File: rtl/frfcfs_queue.sv
// Age-ordered request store: slot 0 is oldest, removal compacts upward slots down.
module frfcfs_queue #(
  parameter int DEPTH = 8,
  parameter int EW    = 12,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       push_i,
  input  logic [EW-1:0]              push_data_i,
  input  logic                       pop_i,
  input  logic [IDX_W-1:0]           pop_idx_i,
  output logic [DEPTH-1:0][EW-1:0]   data_o,
  output logic [DEPTH-1:0]           vld_o,
  output logic [CNT_W-1:0]           count_o
);
  logic [DEPTH-1:0][EW-1:0] data_q;
  logic [DEPTH-1:0][EW-1:0] shf_data;
  logic [CNT_W-1:0]         count_q;
  logic [CNT_W-1:0]         cnt_after;

  assign cnt_after = count_q - CNT_W'(pop_i);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic take_up;
    logic wr_here;
    assign take_up = pop_i && (i >= int'(pop_idx_i));
    assign wr_here = push_i && (int'(cnt_after) == i);
    if (i < DEPTH - 1) begin : g_mid
      assign shf_data[i] = take_up ? data_q[i+1] : data_q[i];
    end else begin : g_top
      assign shf_data[i] = take_up ? '0 : data_q[i];
    end
    assign vld_o[i] = (int'(count_q) > i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) data_q[i] <= '0;
      else         data_q[i] <= wr_here ? push_data_i : shf_data[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_q <= '0;
    else         count_q <= cnt_after + CNT_W'(push_i);
  end

  assign data_o  = data_q;
  assign count_o = count_q;
endmodule

// File: rtl/frfcfs_bank_table.sv
// Per-bank open-row record.
module frfcfs_bank_table #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 8,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            set_i,
  input  logic [BANK_W-1:0]               set_bank_i,
  input  logic [ROW_W-1:0]                set_row_i,
  input  logic [NUM_BANKS-1:0]            close_i,
  output logic [NUM_BANKS-1:0]            open_o,
  output logic [NUM_BANKS-1:0][ROW_W-1:0] row_o
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit_here;
    assign hit_here = set_i && (int'(set_bank_i) == b);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_o[b] <= 1'b0;
        row_o[b]  <= '0;
      end else if (hit_here) begin
        open_o[b] <= 1'b1;
        row_o[b]  <= set_row_i;
      end else if (close_i[b]) begin
        open_o[b] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/frfcfs_pick.sv
// Readiness classification and selection.
module frfcfs_pick
  import frfcfs_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 8,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0]                vld_i,
  input  logic [DEPTH-1:0][BANK_W-1:0]    bank_i,
  input  logic [DEPTH-1:0][ROW_W-1:0]     row_i,
  input  logic [NUM_BANKS-1:0]            open_i,
  input  logic [NUM_BANKS-1:0][ROW_W-1:0] open_row_i,
  input  policy_e                         policy_i,
  output logic                            any_o,
  output logic [IDX_W-1:0]                idx_o,
  output logic                            hit_o
);
  logic [DEPTH-1:0] ready;
  logic [IDX_W-1:0] first_rdy;
  logic             found;

  for (genvar i = 0; i < DEPTH; i++) begin : g_rdy
    assign ready[i] = vld_i[i] && open_i[bank_i[i]] && (open_row_i[bank_i[i]] == row_i[i]);
  end

  always_comb begin
    first_rdy = '0;
    found     = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (ready[i]) begin
        first_rdy = IDX_W'(i);
        found     = 1'b1;
      end
    end
  end

  assign any_o = vld_i[0];
  assign idx_o = (policy_i == POL_READY_FIRST && found) ? first_rdy : '0;
  assign hit_o = ready[idx_o];
endmodule

// File: rtl/frfcfs_sched.sv
module frfcfs_sched
  import frfcfs_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 8,
  parameter int TID_W     = 2,
  parameter int DEPTH     = 8,
  parameter int CNT_W     = 16,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int QC_W     = $clog2(DEPTH + 1),
  localparam int EW       = TID_W + BANK_W + ROW_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 fcfs_mode_i,
  input  logic                 enq_valid_i,
  input  logic [BANK_W-1:0]    enq_bank_i,
  input  logic [ROW_W-1:0]     enq_row_i,
  input  logic [TID_W-1:0]     enq_tid_i,
  output logic                 full_o,
  input  logic [NUM_BANKS-1:0] bank_close_i,
  input  logic                 issue_slot_i,
  output logic                 issue_valid_o,
  output logic [BANK_W-1:0]    issue_bank_o,
  output logic [ROW_W-1:0]     issue_row_o,
  output logic [TID_W-1:0]     issue_tid_o,
  output logic                 issue_hit_o,
  output logic [CNT_W-1:0]     hit_cnt_o,
  output logic [CNT_W-1:0]     miss_cnt_o
);
  logic [DEPTH-1:0][EW-1:0]        q_data;
  logic [DEPTH-1:0]                q_vld;
  logic [QC_W-1:0]                 q_count;
  logic [DEPTH-1:0][BANK_W-1:0]    q_bank;
  logic [DEPTH-1:0][ROW_W-1:0]     q_row;
  logic [NUM_BANKS-1:0]            tbl_open;
  logic [NUM_BANKS-1:0][ROW_W-1:0] tbl_row;
  logic                            sel_any;
  logic [IDX_W-1:0]                sel_idx;
  logic                            sel_hit;
  logic                            push;
  logic [EW-1:0]                   sel_data;
  policy_e                         policy;

  for (genvar i = 0; i < DEPTH; i++) begin : g_split
    assign q_row[i]  = q_data[i][ROW_W-1:0];
    assign q_bank[i] = q_data[i][ROW_W +: BANK_W];
  end

  assign policy = fcfs_mode_i ? POL_ARRIVAL : POL_READY_FIRST;
  assign full_o = (int'(q_count) == DEPTH);
  assign push   = enq_valid_i && !full_o;

  frfcfs_queue #(.DEPTH(DEPTH), .EW(EW)) u_queue (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_data_i ({enq_tid_i, enq_bank_i, enq_row_i}),
    .pop_i       (issue_valid_o),
    .pop_idx_i   (sel_idx),
    .data_o      (q_data),
    .vld_o       (q_vld),
    .count_o     (q_count)
  );

  frfcfs_pick #(.DEPTH(DEPTH), .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_pick (
    .vld_i      (q_vld),
    .bank_i     (q_bank),
    .row_i      (q_row),
    .open_i     (tbl_open),
    .open_row_i (tbl_row),
    .policy_i   (policy),
    .any_o      (sel_any),
    .idx_o      (sel_idx),
    .hit_o      (sel_hit)
  );

  frfcfs_bank_table #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (issue_valid_o && !sel_hit),
    .set_bank_i (issue_bank_o),
    .set_row_i  (issue_row_o),
    .close_i    (bank_close_i),
    .open_o     (tbl_open),
    .row_o      (tbl_row)
  );

  assign sel_data      = q_data[sel_idx];
  assign issue_valid_o = issue_slot_i && sel_any;
  assign issue_row_o   = sel_data[ROW_W-1:0];
  assign issue_bank_o  = sel_data[ROW_W +: BANK_W];
  assign issue_tid_o   = sel_data[ROW_W + BANK_W +: TID_W];
  assign issue_hit_o   = issue_valid_o && sel_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_cnt_o  <= '0;
      miss_cnt_o <= '0;
    end else if (issue_valid_o) begin
      if (sel_hit) hit_cnt_o  <= hit_cnt_o + 1'b1;
      else         miss_cnt_o <= miss_cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/frfcfs_sched_chk.sv
module frfcfs_sched_chk #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 8,
  parameter int DEPTH     = 8,
  parameter int CNT_W     = 16,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int QC_W     = $clog2(DEPTH + 1)
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            issue_slot_i,
  input logic                            issue_valid_o,
  input logic                            issue_hit_o,
  input logic [BANK_W-1:0]               issue_bank_o,
  input logic [ROW_W-1:0]                issue_row_o,
  input logic                            full_o,
  input logic [CNT_W-1:0]                hit_cnt_o,
  input logic [CNT_W-1:0]                miss_cnt_o,
  input logic [QC_W-1:0]                 q_count,
  input logic [NUM_BANKS-1:0]            tbl_open,
  input logic [NUM_BANKS-1:0][ROW_W-1:0] tbl_row
);
  a_r9_valid_needs_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> issue_slot_i);

  a_r8_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(q_count) <= DEPTH);

  a_r8_full_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !issue_valid_o) |=> full_o);

  a_r6_miss_opens_row: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_o && !issue_hit_o) |=>
      (tbl_open[$past(issue_bank_o)] && tbl_row[$past(issue_bank_o)] == $past(issue_row_o)));

  a_r2_hit_matches_table: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_hit_o |-> (tbl_open[issue_bank_o] && tbl_row[issue_bank_o] == issue_row_o));

  a_r10_hit_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_hit_o |=> hit_cnt_o == $past(hit_cnt_o) + 1'b1);

  a_r10_miss_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_o && !issue_hit_o) |=> miss_cnt_o == $past(miss_cnt_o) + 1'b1);

  a_r10_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_valid_o |=> ($stable(hit_cnt_o) && $stable(miss_cnt_o)));
endmodule

bind frfcfs_sched frfcfs_sched_chk #(
  .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .issue_slot_i  (issue_slot_i),
  .issue_valid_o (issue_valid_o),
  .issue_hit_o   (issue_hit_o),
  .issue_bank_o  (issue_bank_o),
  .issue_row_o   (issue_row_o),
  .full_o        (full_o),
  .hit_cnt_o     (hit_cnt_o),
  .miss_cnt_o    (miss_cnt_o),
  .q_count       (q_count),
  .tbl_open      (tbl_open),
  .tbl_row       (tbl_row)
);

// File: tb/tb_frfcfs_sched.sv
module tb_frfcfs_sched;
  localparam int NB = 4;
  localparam int RW = 8;
  localparam int TW = 2;
  localparam int D  = 8;
  localparam int CW = 16;
  localparam int BW = 2;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          fcfs_mode_i = 1'b0;
  logic          enq_valid_i = 1'b0;
  logic [BW-1:0] enq_bank_i = '0;
  logic [RW-1:0] enq_row_i = '0;
  logic [TW-1:0] enq_tid_i = '0;
  logic          full_o;
  logic [NB-1:0] bank_close_i = '0;
  logic          issue_slot_i = 1'b0;
  logic          issue_valid_o;
  logic [BW-1:0] issue_bank_o;
  logic [RW-1:0] issue_row_o;
  logic [TW-1:0] issue_tid_o;
  logic          issue_hit_o;
  logic [CW-1:0] hit_cnt_o;
  logic [CW-1:0] miss_cnt_o;

  always #5 clk = ~clk;

  frfcfs_sched #(.NUM_BANKS(NB), .ROW_W(RW), .TID_W(TW), .DEPTH(D), .CNT_W(CW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .fcfs_mode_i(fcfs_mode_i),
    .enq_valid_i(enq_valid_i), .enq_bank_i(enq_bank_i), .enq_row_i(enq_row_i),
    .enq_tid_i(enq_tid_i), .full_o(full_o), .bank_close_i(bank_close_i),
    .issue_slot_i(issue_slot_i), .issue_valid_o(issue_valid_o),
    .issue_bank_o(issue_bank_o), .issue_row_o(issue_row_o), .issue_tid_o(issue_tid_o),
    .issue_hit_o(issue_hit_o), .hit_cnt_o(hit_cnt_o), .miss_cnt_o(miss_cnt_o)
  );

  typedef struct { int bank; int row; int tid; } req_t;
  req_t mq[$];
  int   m_open[NB];
  int   m_row[NB];
  int   m_hits = 0, m_miss = 0;
  int   total = 0, bad = 0;
  int   last_valid, last_row, last_bank, last_hit;
  bit   finished = 0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit m_ready(input int k);
    return m_open[mq[k].bank] != 0 && m_row[mq[k].bank] == mq[k].row;
  endfunction

  task automatic step(input bit en, input int b, input int r, input int t,
                      input bit slot, input bit mode, input logic [NB-1:0] cls);
    int  idx = 0;
    bit  ev, eh, was_full;
    string stag;
    enq_valid_i = en; enq_bank_i = BW'(b); enq_row_i = RW'(r); enq_tid_i = TW'(t);
    issue_slot_i = slot; fcfs_mode_i = mode; bank_close_i = cls;
    #1;
    ev = slot && mq.size() > 0;
    if (ev && !mode) begin
      bit found = 0;
      for (int k = 0; k < mq.size(); k++)
        if (!found && m_ready(k)) begin idx = k; found = 1; end
    end
    eh = ev && m_ready(idx);
    was_full = (mq.size() == D);
    stag = mode ? "R5" : "R3 R4";
    chk(issue_valid_o == ev, "R9", "issue_valid", int'(issue_valid_o), int'(ev));
    chk(full_o == was_full, "R8", "full", int'(full_o), int'(was_full));
    chk(int'(hit_cnt_o) == m_hits, "R10", "hit_cnt", int'(hit_cnt_o), m_hits);
    chk(int'(miss_cnt_o) == m_miss, "R10", "miss_cnt", int'(miss_cnt_o), m_miss);
    if (ev) begin
      chk(int'(issue_bank_o) == mq[idx].bank, stag, "bank", int'(issue_bank_o), mq[idx].bank);
      chk(int'(issue_row_o) == mq[idx].row, stag, "row", int'(issue_row_o), mq[idx].row);
      chk(int'(issue_tid_o) == mq[idx].tid, stag, "tid", int'(issue_tid_o), mq[idx].tid);
      chk(issue_hit_o == eh, "R2", "hit", int'(issue_hit_o), int'(eh));
    end
    last_valid = int'(issue_valid_o); last_row = int'(issue_row_o);
    last_bank = int'(issue_bank_o); last_hit = int'(issue_hit_o);
    @(posedge clk);
    begin
      int ib = -1;
      if (ev) begin
        if (eh) m_hits++;
        else begin
          m_miss++;
          ib = mq[idx].bank;
          m_open[ib] = 1;
          m_row[ib] = mq[idx].row;
        end
        mq.delete(idx);
      end
      for (int k = 0; k < NB; k++) if (cls[k] && k != ib) m_open[k] = 0;
      if (en && !was_full) mq.push_back('{b, r, t});
    end
    @(negedge clk);
  endtask

  task automatic enq(input int b, input int r, input int t);
    step(1, b, r, t, 0, 0, '0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seq[4];
    for (int k = 0; k < NB; k++) begin m_open[k] = 0; m_row[k] = 0; end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1: reset state
    issue_slot_i = 1'b1;
    #1;
    chk(issue_valid_o == 1'b0, "R1", "valid after reset", int'(issue_valid_o), 0);
    chk(full_o == 1'b0, "R1", "full after reset", int'(full_o), 0);
    chk(hit_cnt_o == '0 && miss_cnt_o == '0, "R1", "counters after reset", int'(hit_cnt_o + miss_cnt_o), 0);
    @(negedge clk);
    enq(0, 5, 1);
    step(0, 0, 0, 0, 1, 0, '0);
    chk(last_valid == 1 && last_hit == 0, "R1", "first issue is miss", last_hit, 0);
    // R6: miss opened bank0 row5
    enq(0, 5, 2);
    step(0, 0, 0, 0, 1, 0, '0);
    chk(last_hit == 1, "R6", "second access hits", last_hit, 1);
    // R3: hit run overtakes older miss
    enq(0, 9, 0); enq(0, 5, 1); enq(0, 5, 2); enq(0, 5, 3);
    for (int k = 0; k < 4; k++) begin
      step(0, 0, 0, 0, 1, 0, '0);
      seq[k] = last_row;
    end
    chk(seq[0] == 5 && seq[1] == 5 && seq[2] == 5, "R3", "hits first", seq[2], 5);
    chk(seq[3] == 9, "R3", "miss waits for run", seq[3], 9);
    // R5: arrival order ignores the ready entry
    enq(1, 1, 0); enq(0, 9, 1);
    step(0, 0, 0, 0, 1, 1, '0);
    chk(last_row == 1, "R5", "oldest first in fcfs", last_row, 1);
    step(0, 0, 0, 0, 1, 1, '0);
    chk(last_row == 9, "R5", "second in fcfs", last_row, 9);
    // R4: two misses, oldest first
    enq(2, 4, 0); enq(3, 6, 0);
    step(0, 0, 0, 0, 1, 0, '0);
    chk(last_bank == 2, "R4", "older miss first", last_bank, 2);
    step(0, 0, 0, 0, 1, 0, '0);
    // R7: close bank0 then access its old row
    step(1, 0, 9, 2, 0, 0, 4'b0001);
    step(0, 0, 0, 0, 1, 0, '0);
    chk(last_hit == 0, "R7", "closed bank misses", last_hit, 0);
    // R7: close and miss in same cycle, miss wins
    enq(1, 7, 0);
    step(0, 0, 0, 0, 1, 0, 4'b0010);
    enq(1, 7, 1);
    step(0, 0, 0, 0, 1, 0, '0);
    chk(last_hit == 1, "R7", "issue overrides close", last_hit, 1);
    // R8: fill, overflow dropped
    for (int k = 0; k < D; k++) enq(3, k, 0);
    #1;
    chk(full_o == 1'b1, "R8", "full at depth", int'(full_o), 1);
    @(negedge clk);
    enq(2, 200, 3);
    for (int k = 0; k < D; k++) begin
      step(0, 0, 0, 0, 1, 1, '0);
      chk(last_row == k, "R8", "drain order", last_row, k);
    end
    step(0, 0, 0, 0, 1, 1, '0);
    chk(last_valid == 0, "R8", "dropped enqueue absent", last_valid, 0);
    // mixed traffic
    for (int n = 0; n < 400; n++) begin
      logic [NB-1:0] c;
      c = ($urandom % 8 == 0) ? NB'($urandom) : '0;
      step(($urandom % 3) != 0, $urandom % NB, $urandom % 4, $urandom % 4,
           ($urandom % 2) == 0, (n / 100) % 2 == 1, c);
    end
    while (mq.size() > 0) step(0, 0, 0, 0, 1, 0, '0);
    #1;
    chk(int'(hit_cnt_o) == m_hits, "R10", "final hits", int'(hit_cnt_o), m_hits);
    chk(int'(miss_cnt_o) == m_miss, "R10", "final misses", int'(miss_cnt_o), m_miss);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule